// File: doc/BRIEF.md
# I2C Bus Condition and Clock-Hold Controller

This block is the I2C-mode companion of a serial shift unit. It watches the synchronized SCL and SDA lines and recognises START and STOP conditions. It keeps a START flag, which can raise an interrupt, and a STOP-seen flag. It also keeps an arbitration-lost bit. That bit is set when the block lets SDA float high during a transmit but reads the line back low.

The block never drives a line high. Each pin has only a pull-low enable, so both lines behave as open-drain. When the shift unit reports a finished byte, SCL is held low. This stretches the clock until software writes the release bit, and the next START clears that bit again. Register writes reach the block as single-cycle strobes: bit-count load, release set and flag clear. A software reset level clears every flag.

Top module: `i2c_cond_hold`

## Requirements
- R1: After `rst`, `start_flag`, `stop_flag`, `arb_lost`, `scl_rel` and `irq` are 0. With `i2c_en` at 0, `scl_oe` and `sda_oe` are also 0.
- R2: A START condition sets `start_flag` at the next clock edge. A START is SDA sampled 1 and then 0 on two consecutive clocks, with SCL sampled 1 on both. SDA changes while SCL is low set no flag. `irq` equals `start_flag AND start_ie` in the same cycle.
- R3: A STOP condition sets `stop_flag` at the next clock edge. A STOP is SDA sampled 0 and then 1 on two consecutive clocks, with SCL sampled 1 on both.
- R4: `stop_flag` clears at the edge where `cnt_load` is 1, `cnt_value` is nonzero and `clr_ctl` is 0. A load of zero, or any load while `clr_ctl` is 1, leaves the flag unchanged.
- R5: `scl_oe` (pull SCL low) is 1 in the same cycle exactly when the block is active, `done_flag` is 1 and `scl_rel` is 0. The block is active when `i2c_en` is 1 and `soft_rst` is 0.
- R6: A `rel_set` strobe sets `scl_rel` at the next edge. A detected START clears it, and the START wins when both occur in the same cycle.
- R7: `arb_lost` sets at the next edge when all of these hold: the block is active, `tx_en` is 1, `sda_tx` is 1, `scl_in` is 1 and `sda_in` is 0. While `arb_lost` is 1, `sda_oe` is 0.
- R8: `sda_oe` (pull SDA low) is 1 exactly when the block is active, `tx_en` is 1, `sda_tx` is 0 and `arb_lost` is 0. No output ever drives a line high.
- R9: While `soft_rst` is 1, all four flags are cleared at each edge, no condition is detected and both pull-low enables are 0.
- R10: Each bit of `flag_clr_mask` clears one flag at the next edge: bit 0 `start_flag`, bit 1 `stop_flag`, bit 2 `arb_lost`. A set event in the same cycle takes priority over the clear.
- R11: With `i2c_en` at 0, no START, STOP or arbitration event is recorded, and both pull-low enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i2c_en | input | 1 | I2C mode enable |
| soft_rst | input | 1 | Software reset level |
| start_ie | input | 1 | START interrupt enable |
| clr_ctl | input | 1 | 1 blocks the automatic STOP-flag clear on a count load |
| tx_en | input | 1 | Data output enabled by the shift unit |
| sda_tx | input | 1 | Bit the shift unit presents (1 = release SDA) |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| done_flag | input | 1 | Transfer-complete flag from the shift unit |
| cnt_load | input | 1 | Bit-count register write strobe |
| cnt_value | input | CNT_W | Bit count being written |
| rel_set | input | 1 | Write strobe setting the SCL release bit |
| flag_clr_mask | input | 3 | Per-flag clear strobes |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| start_flag | output | 1 | START received |
| stop_flag | output | 1 | STOP received |
| arb_lost | output | 1 | Arbitration lost |
| scl_rel | output | 1 | SCL release bit |
| irq | output | 1 | START interrupt |

## Verification
The bench builds the block with its default CNT_W of 5. With that width, directed loads of zero and of nonzero counts can be mixed with random loads across the whole 0 to 31 range. Random traffic on the two lines often produces START and STOP conditions, line changes while SCL is low, and readbacks that lose arbitration. These arrive together with release, clear and software-reset strobes, so the same-cycle priorities are reached often.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int CLR_W     = 3;
    localparam int CLR_START = 0;
    localparam int CLR_STOP  = 1;
    localparam int CLR_ARB   = 2;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic arb;
    } bus_evt_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic arb;
        logic rel;
    } stat_t;

    // Classify one sample pair of the bus lines.
    function automatic bus_evt_t classify(line_t prev, line_t now, logic active,
                                          logic chk, logic tx_bit);
        bus_evt_t e;
        logic     scl_hi;
        scl_hi  = prev.scl & now.scl;
        e.start = active & scl_hi & prev.sda & ~now.sda;
        e.stop  = active & scl_hi & ~prev.sda & now.sda;
        e.arb   = active & chk & tx_bit & now.scl & ~now.sda;
        return e;
    endfunction

endpackage

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_cond_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  logic     tx_en,
    input  logic     sda_tx,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    line_t prev_q;
    line_t now_s;

    assign now_s = '{scl: scl_in, sda: sda_in};

    // Idle bus is high on both lines, so reset to ones: no false edge.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else     prev_q <= now_s;
    end

    assign evt = classify(prev_q, now_s, active, tx_en, sda_tx);

    // START and STOP are mutually exclusive on any sample pair
    assert_start_stop_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(evt.start && evt.stop));

endmodule

// File: rtl/i2c_cond_flags.sv
module i2c_cond_flags
    import i2c_cond_pkg::*;
#(
    parameter int CNT_W = 5
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  bus_evt_t         evt,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             clr_ctl,
    input  logic             rel_set,
    input  logic [CLR_W-1:0] clr_mask,
    output stat_t            stat
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic  auto_clr;
    stat_t nxt;

    assign auto_clr = cnt_load & (cnt_value != CNT_ZERO) & ~clr_ctl;

    always_comb begin
        nxt = stat;
        if (clr_mask[CLR_START]) nxt.start = 1'b0;
        if (clr_mask[CLR_STOP] || auto_clr) nxt.stop = 1'b0;
        if (clr_mask[CLR_ARB]) nxt.arb = 1'b0;
        if (rel_set) nxt.rel = 1'b1;
        // set events dominate clears
        if (evt.start) begin
            nxt.start = 1'b1;
            nxt.rel   = 1'b0;
        end
        if (evt.stop) nxt.stop = 1'b1;
        if (evt.arb)  nxt.arb  = 1'b1;
        if (soft_rst) nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= nxt;
    end

    assert_start_set_R2: assert property (@(posedge clk) disable iff (rst)
        (evt.start && !soft_rst) |=> stat.start);

    assert_stop_set_R3: assert property (@(posedge clk) disable iff (rst)
        (evt.stop && !soft_rst) |=> stat.stop);

    assert_stop_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (stat.stop && !soft_rst && !clr_mask[CLR_STOP] &&
         (!cnt_load || cnt_value == CNT_ZERO || clr_ctl)) |=> stat.stop);

    assert_rel_start_R6: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> !stat.rel);

    assert_arb_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (stat.arb && !soft_rst && !clr_mask[CLR_ARB]) |=> stat.arb);

    assert_soft_clear_R9: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (stat == '0));

endmodule

// File: rtl/i2c_cond_drive.sv
module i2c_cond_drive
    import i2c_cond_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  done_flag,
    input  logic  tx_en,
    input  logic  sda_tx,
    input  logic  start_ie,
    input  stat_t stat,
    output logic  scl_oe,
    output logic  sda_oe,
    output logic  irq
);

    // Pull-low enables only: a released line floats to its pull-up.
    assign scl_oe = active & done_flag & ~stat.rel;
    assign sda_oe = active & tx_en & ~sda_tx & ~stat.arb;
    assign irq    = stat.start & start_ie;

    // Once arbitration is lost, SDA stays released until the bit is cleared
    assert_arb_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (stat.arb && $stable(stat.arb)) |-> !sda_oe);

endmodule

// File: rtl/i2c_cond_hold.sv
module i2c_cond_hold
    import i2c_cond_pkg::*;
#(
    parameter int CNT_W = 5
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             i2c_en,
    input  logic             soft_rst,
    input  logic             start_ie,
    input  logic             clr_ctl,
    input  logic             tx_en,
    input  logic             sda_tx,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             done_flag,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             rel_set,
    input  logic [2:0]       flag_clr_mask,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             start_flag,
    output logic             stop_flag,
    output logic             arb_lost,
    output logic             scl_rel,
    output logic             irq
);

    logic     active;
    bus_evt_t evt;
    stat_t    stat;

    assign active = i2c_en & ~soft_rst;

    i2c_cond_detect u_detect (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .tx_en  (tx_en),
        .sda_tx (sda_tx),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_cond_flags #(.CNT_W(CNT_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .evt       (evt),
        .cnt_load  (cnt_load),
        .cnt_value (cnt_value),
        .clr_ctl   (clr_ctl),
        .rel_set   (rel_set),
        .clr_mask  (flag_clr_mask),
        .stat      (stat)
    );

    i2c_cond_drive u_drive (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .done_flag (done_flag),
        .tx_en     (tx_en),
        .sda_tx    (sda_tx),
        .start_ie  (start_ie),
        .stat      (stat),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .irq       (irq)
    );

    assign start_flag = stat.start;
    assign stop_flag  = stat.stop;
    assign arb_lost   = stat.arb;
    assign scl_rel    = stat.rel;

    // A disabled block records no START
    assert_idle_no_start_R11: assert property (@(posedge clk) disable iff (rst)
        (!i2c_en && !start_flag && !flag_clr_mask[0]) |=> !start_flag);

endmodule

// File: tb/i2c_cond_hold_bench.sv
`timescale 1ns/1ps
module i2c_cond_hold_bench;

    localparam int CNT_W = 5;
    localparam time CLK_P = 20ns;

    logic clk = 1'b0;
    logic rst, i2c_en, soft_rst, start_ie, clr_ctl, tx_en, sda_tx;
    logic scl_in, sda_in, done_flag, cnt_load, rel_set;
    logic [CNT_W-1:0] cnt_value;
    logic [2:0] flag_clr_mask;
    logic scl_oe, sda_oe, start_flag, stop_flag, arb_lost, scl_rel, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    bit m_start, m_stop, m_arb, m_rel, p_scl, p_sda;

    always #(CLK_P/2) clk = ~clk;

    i2c_cond_hold #(.CNT_W(CNT_W)) u_i2c_cond_hold (
        .clk(clk), .rst(rst), .i2c_en(i2c_en), .soft_rst(soft_rst),
        .start_ie(start_ie), .clr_ctl(clr_ctl), .tx_en(tx_en), .sda_tx(sda_tx),
        .scl_in(scl_in), .sda_in(sda_in), .done_flag(done_flag),
        .cnt_load(cnt_load), .cnt_value(cnt_value), .rel_set(rel_set),
        .flag_clr_mask(flag_clr_mask), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .start_flag(start_flag), .stop_flag(stop_flag), .arb_lost(arb_lost),
        .scl_rel(scl_rel), .irq(irq)
    );

    task automatic chk(string req, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
        end
    endtask

    function automatic bit exp_active();
        return i2c_en & ~soft_rst;
    endfunction

    // One clock: check same-cycle outputs, step the model, check flags.
    task automatic tick();
        bit act, st, sp, ab, ld;
        #1;
        act = exp_active();
        chk("R5", "scl_oe", scl_oe, act & done_flag & ~m_rel);
        chk("R8", "sda_oe", sda_oe, act & tx_en & ~sda_tx & ~m_arb);
        chk("R2", "irq", irq, m_start & start_ie);
        st = act & p_scl & scl_in & p_sda & ~sda_in;
        sp = act & p_scl & scl_in & ~p_sda & sda_in;
        ab = act & tx_en & sda_tx & scl_in & ~sda_in;
        ld = cnt_load & (cnt_value != 0) & ~clr_ctl;
        @(posedge clk);
        p_scl = scl_in;
        p_sda = sda_in;
        if (soft_rst) begin
            m_start = 0; m_stop = 0; m_arb = 0; m_rel = 0;
        end else begin
            m_start = st | (m_start & ~flag_clr_mask[0]);
            m_stop  = sp | (m_stop & ~flag_clr_mask[1] & ~ld);
            m_arb   = ab | (m_arb & ~flag_clr_mask[2]);
            m_rel   = ~st & (rel_set | m_rel);
        end
        @(negedge clk);
        chk("R2", "start_flag", start_flag, m_start);
        chk("R3", "stop_flag", stop_flag, m_stop);
        chk("R7", "arb_lost", arb_lost, m_arb);
        chk("R6", "scl_rel", scl_rel, m_rel);
    endtask

    task automatic lines(logic s, logic d);
        scl_in = s;
        sda_in = d;
    endtask

    initial begin
        int unsigned seed_v;
        rst = 1; i2c_en = 0; soft_rst = 0; start_ie = 0; clr_ctl = 0;
        tx_en = 0; sda_tx = 1; scl_in = 1; sda_in = 1; done_flag = 0;
        cnt_load = 0; cnt_value = 0; rel_set = 0; flag_clr_mask = 0;
        m_start = 0; m_stop = 0; m_arb = 0; m_rel = 0; p_scl = 1; p_sda = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1", "start_flag", start_flag, 0);
        chk("R1", "stop_flag", stop_flag, 0);
        chk("R1", "arb_lost", arb_lost, 0);
        chk("R1", "scl_rel", scl_rel, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "scl_oe", scl_oe, 0);
        chk("R1", "sda_oe", sda_oe, 0);
        @(negedge clk);

        // R2 START with interrupt enabled
        i2c_en = 1; start_ie = 1;
        lines(1, 1); tick();
        lines(1, 0); tick();
        chk("R2", "start_flag after START", start_flag, 1);
        #1 chk("R2", "irq with enable", irq, 1);
        start_ie = 0;
        #1 chk("R2", "irq masked", irq, 0);

        // R10 clear START flag
        flag_clr_mask = 3'b001; tick(); flag_clr_mask = 0;
        chk("R10", "start cleared", start_flag, 0);

        // R3 STOP
        lines(1, 1); tick();
        chk("R3", "stop_flag after STOP", stop_flag, 1);

        // R4 auto clear rules
        cnt_load = 1; cnt_value = 0; tick();
        chk("R4", "zero load keeps stop", stop_flag, 1);
        clr_ctl = 1; cnt_value = 5; tick();
        chk("R4", "clr_ctl keeps stop", stop_flag, 1);
        clr_ctl = 0; tick();
        chk("R4", "nonzero load clears stop", stop_flag, 0);
        cnt_load = 0;

        // R2 edges with SCL low are ignored
        lines(0, 1); tick();
        lines(0, 0); tick();
        lines(0, 1); tick();
        chk("R2", "no START with SCL low", start_flag, 0);
        chk("R3", "no STOP with SCL low", stop_flag, 0);
        lines(1, 1); tick();

        // R5 / R6 clock hold and release
        done_flag = 1; tick();
        #1 chk("R5", "SCL held", scl_oe, 1);
        rel_set = 1; tick(); rel_set = 0;
        chk("R6", "release set", scl_rel, 1);
        #1 chk("R5", "SCL released", scl_oe, 0);
        lines(1, 0); tick();
        chk("R6", "START clears release", scl_rel, 0);
        #1 chk("R5", "SCL held again", scl_oe, 1);
        lines(1, 1); tick();
        rel_set = 1; lines(1, 0); tick(); rel_set = 0;
        chk("R6", "START beats release set", scl_rel, 0);
        done_flag = 0;

        // R7 / R8 arbitration and open-drain drive
        flag_clr_mask = 3'b011; tick(); flag_clr_mask = 0;
        tx_en = 1; sda_tx = 0; lines(0, 0);
        #1 chk("R8", "SDA pulled for 0", sda_oe, 1);
        sda_tx = 1;
        #1 chk("R8", "SDA released for 1", sda_oe, 0);
        lines(1, 0); tick();
        chk("R7", "arbitration lost", arb_lost, 1);
        sda_tx = 0;
        #1 chk("R7", "no pull after loss", sda_oe, 0);
        sda_tx = 1; flag_clr_mask = 3'b100; tick(); flag_clr_mask = 0;
        chk("R10", "set beats clear", arb_lost, 1);
        lines(0, 0); flag_clr_mask = 3'b100; tick(); flag_clr_mask = 0;
        chk("R10", "arb cleared", arb_lost, 0);
        tx_en = 0;

        // R9 software reset
        lines(1, 1); tick();
        rel_set = 1; tick(); rel_set = 0;
        done_flag = 1; soft_rst = 1; lines(1, 0); tick();
        chk("R9", "start suppressed", start_flag, 0);
        chk("R9", "release cleared", scl_rel, 0);
        #1 chk("R9", "no SCL pull", scl_oe, 0);
        soft_rst = 0; done_flag = 0;

        // R11 disabled block
        i2c_en = 0; lines(1, 1); tick();
        lines(1, 0); tick();
        chk("R11", "no START when disabled", start_flag, 0);
        lines(1, 1); tick();
        chk("R11", "no STOP when disabled", stop_flag, 0);
        done_flag = 1; tx_en = 1; sda_tx = 0;
        #1 chk("R11", "no SCL pull when disabled", scl_oe, 0);
        chk("R11", "no SDA pull when disabled", sda_oe, 0);
        done_flag = 0; tx_en = 0; sda_tx = 1;

        // constrained random traffic
        seed_v = $urandom(32'h0001_5eed);
        for (int i = 0; i < 4000; i++) begin
            i2c_en        = ($urandom_range(15) != 0);
            soft_rst      = ($urandom_range(31) == 0);
            start_ie      = $urandom_range(1);
            clr_ctl       = ($urandom_range(3) == 0);
            tx_en         = $urandom_range(1);
            sda_tx        = $urandom_range(1);
            done_flag     = $urandom_range(1);
            cnt_load      = ($urandom_range(7) == 0);
            cnt_value     = CNT_W'($urandom_range(31));
            rel_set       = ($urandom_range(7) == 0);
            flag_clr_mask = ($urandom_range(7) == 0) ? 3'($urandom_range(7)) : 3'b000;
            if ($urandom_range(3) == 0) scl_in = ~scl_in;
            if ($urandom_range(2) == 0) sda_in = ~sda_in;
            tick();
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule